// File: doc/BRIEF.md
# Decoded Johnson decade counter

A ten-state counter whose state lives in a five-bit twisted-ring shift register. Ten one-hot outputs are decoded from the ring. A carry output is a square wave with 50% duty at one tenth of the count rate, so it can drive the count input of a following stage. Each decoded output looks at just two adjacent ring bits, and only one ring bit changes per step, so the outputs never pass through a wrong code.

The block runs entirely on one system clock. The count clock and the active-low enable are treated as slow level signals. Each passes through a two-flop synchroniser, and the count advances on detected edges. The count advances in two cases:
- a rising count clock while the enable is low;
- a falling enable while the count clock is held high.

Reset asserts asynchronously and releases synchronously. If the ring ever holds one of the 22 unused patterns, the next advance puts it back at count 0. Feeding decoded output N back into reset gives a divide-by-N counter.

Top module: `johnson_decade`

## Requirements
- R1: With `cnt_en_n` low, each rising edge of `cnt_clk` advances the count by one, modulo ten. The outputs change on the third rising `clk` edge after the input change: two edges for the synchroniser and one for the state.
- R2: Output `q[k]` is high exactly when the count is k, and all other bits of `q` are low.
- R3: While `cnt_en_n` is high, rising edges of `cnt_clk` are ignored and the count holds.
- R4: A falling edge of `cnt_en_n` while `cnt_clk` is high advances the count by one.
- R5: A high `rst` immediately forces count 0 (`q` = 10'b0000000001, `carry` = 1) and overrides all count activity. Counting resumes once `rst` is released.
- R6: `carry` is high for counts 0 to 4 and low for counts 5 to 9.
- R7: A ring holding any non-Johnson pattern goes to count 0 on the next advance.
- R8: Tying `q[N]` back into `rst` makes the count run modulo N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, asynchronous assert |
| cnt_clk | input | 1 | Count clock, sampled as a level |
| cnt_en_n | input | 1 | Active-low count enable, sampled as a level |
| q | output | 10 | One-hot decoded count |
| carry | output | 1 | High for counts 0 to 4 |

## Verification
The hardest situation to reach is a ring holding an unused pattern, because no sequence at the ports can produce one. For each of the 22 illegal patterns, the bench overrides the ring register between clock edges. It then releases the register and applies one count pulse, and checks that the outputs show count 0. Two other cases also need care: the divide-by-N loop, where the reset comes from the block's own output, and reset applied in the middle of a count.

// File: rtl/johnson_decade.sv
module johnson_decade #(
  parameter int SYNC_STAGES = 2,
  localparam int STAGES = 5,
  localparam int OUTS = 2 * STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cnt_clk,
  input  logic            cnt_en_n,
  output logic [OUTS-1:0] q,
  output logic            carry
);

  logic [SYNC_STAGES-1:0] rst_sr, clk_sr, en_sr;
  logic clk_d, en_d, rst_i, adv, legal;
  logic [STAGES-1:0] st, nxt;
  logic [STAGES-2:0] flips;

  always_ff @(posedge clk or posedge rst)
    if (rst) rst_sr <= '1;
    else     rst_sr <= {rst_sr[SYNC_STAGES-2:0], 1'b0};

  assign rst_i = rst_sr[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    clk_sr <= {clk_sr[SYNC_STAGES-2:0], cnt_clk};
    en_sr  <= {en_sr[SYNC_STAGES-2:0], cnt_en_n};
    clk_d  <= clk_sr[SYNC_STAGES-1];
    en_d   <= en_sr[SYNC_STAGES-1];
  end

  assign adv = (clk_sr[SYNC_STAGES-1] & ~clk_d & ~en_sr[SYNC_STAGES-1])
             | (en_d & ~en_sr[SYNC_STAGES-1] & clk_sr[SYNC_STAGES-1]);

  assign flips = st[STAGES-1:1] ^ st[STAGES-2:0];
  assign legal = (flips & (flips - 1'b1)) == '0;
  assign nxt   = legal ? {st[STAGES-2:0], ~st[STAGES-1]} : '0;

  always_ff @(posedge clk or posedge rst_i)
    if (rst_i)    st <= '0;
    else if (adv) st <= nxt;

  for (genvar k = 0; k < STAGES; k++) begin : g_dec
    if (k == 0) begin : g_end
      assign q[0]      = ~st[STAGES-1] & ~st[0];
      assign q[STAGES] =  st[STAGES-1] &  st[0];
    end else begin : g_mid
      assign q[k]          =  st[k-1] & ~st[k];
      assign q[k+STAGES]   = ~st[k-1] &  st[k];
    end
  end

  assign carry = ~st[STAGES-1];

endmodule

module johnson_decade_chk (
  input logic       clk,
  input logic       rst,
  input logic       rst_i,
  input logic       adv,
  input logic [4:0] st,
  input logic [9:0] q,
  input logic       carry
);

  logic ok;
  assign ok = st inside {5'b00000, 5'b00001, 5'b00011, 5'b00111, 5'b01111,
                         5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000};

  // R2
  one_hot_chk: assert property (@(posedge clk) disable iff (rst_i)
    ok |-> $countones(q) == 1);

  // R1
  step_chk: assert property (@(posedge clk) disable iff (rst_i)
    (adv && ok) |=> q == {$past(q[8:0]), $past(q[9])});

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    (!adv && ok) |=> (!ok || $stable(q)));

  // R5
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_i) |-> (q == 10'd1 && carry));

  // R6
  carry_chk: assert property (@(posedge clk) disable iff (rst_i)
    ok |-> carry == |q[4:0]);

  // R7
  recover_chk: assert property (@(posedge clk) disable iff (rst_i)
    (adv && !ok) |=> q == 10'd1);

endmodule

bind johnson_decade johnson_decade_chk u_chk (
  .clk(clk), .rst(rst), .rst_i(rst_i), .adv(adv), .st(st), .q(q), .carry(carry)
);

// File: tb/johnson_decade_bench.sv
`timescale 1ns/1ps
module johnson_decade_bench;

  logic clk = 1'b0;
  logic rst_drv = 1'b1;
  logic div_on = 1'b0;
  logic cnt_clk = 1'b0;
  logic cnt_en_n = 1'b0;
  logic rst;
  logic [9:0] q;
  logic carry;
  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam int DIV_N = 6;

  always #2 clk = ~clk;

  assign rst = rst_drv | (div_on & q[DIV_N]);

  johnson_decade u_johnson_decade (
    .clk(clk), .rst(rst), .cnt_clk(cnt_clk), .cnt_en_n(cnt_en_n),
    .q(q), .carry(carry)
  );

  // {cnt_clk, cnt_en_n, 1'b0, expected count}
  localparam logic [6:0] VEC [24] = '{
    {2'b10, 1'b0, 4'd1}, {2'b00, 1'b0, 4'd1}, {2'b10, 1'b0, 4'd2}, {2'b00, 1'b0, 4'd2},
    {2'b01, 1'b0, 4'd2}, {2'b11, 1'b0, 4'd2}, {2'b01, 1'b0, 4'd2}, {2'b11, 1'b0, 4'd2},
    {2'b10, 1'b0, 4'd3}, {2'b00, 1'b0, 4'd3}, {2'b10, 1'b0, 4'd4}, {2'b00, 1'b0, 4'd4},
    {2'b10, 1'b0, 4'd5}, {2'b11, 1'b0, 4'd5}, {2'b10, 1'b0, 4'd6}, {2'b00, 1'b0, 4'd6},
    {2'b10, 1'b0, 4'd7}, {2'b00, 1'b0, 4'd7}, {2'b10, 1'b0, 4'd8}, {2'b00, 1'b0, 4'd8},
    {2'b10, 1'b0, 4'd9}, {2'b00, 1'b0, 4'd9}, {2'b10, 1'b0, 4'd0}, {2'b00, 1'b0, 4'd0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    cnt_clk = 1'b1; tick(6);
    cnt_clk = 1'b0; tick(6);
  endtask

  task automatic chk(input string tag, input int e);
    logic [9:0] eq;
    eq = 10'd1 << e;
    checks++;
    if (q !== eq || carry !== (e < 5)) begin
      bad++;
      $display("FAIL %s q=%b carry=%b expected q=%b carry=%b", tag, q, carry, eq, e < 5);
    end
  endtask

  function automatic logic is_johnson(input int p);
    for (int k = 0; k < 10; k++) begin
      int code;
      code = (k <= 5) ? ((1 << k) - 1) : (31 & ~((1 << (k - 5)) - 1));
      if (code == p) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    tick(1);
    #1 chk("R5 reset state", 0);
    tick(3);
    rst_drv = 1'b0;
    tick(4);
    chk("R5 after release", 0);

    foreach (VEC[i]) begin
      cnt_clk  = VEC[i][6];
      cnt_en_n = VEC[i][5];
      tick(6);
      chk("R1 R3 R4 table", int'(VEC[i][3:0]));
    end

    begin
      int model = 0;
      for (int i = 0; i < 27; i++) begin
        pulse();
        model = (model + 1) % 10;
        chk("R1 R2 R6 model", model);
      end
    end

    cnt_en_n = 1'b1;
    for (int i = 0; i < 3; i++) pulse();
    chk("R3 enable hold", 7);
    cnt_en_n = 1'b0;

    rst_drv = 1'b1;
    #1 chk("R5 async mid-count", 0);
    pulse();
    chk("R5 overrides clock", 0);
    rst_drv = 1'b0;
    tick(4);
    pulse();
    chk("R5 count resumes", 1);

    for (int p = 0; p < 32; p++) begin
      if (!is_johnson(p)) begin
        @(negedge clk);
        force u_johnson_decade.st = 5'(p);
        tick(1);
        release u_johnson_decade.st;
        tick(1);
        pulse();
        chk("R7 illegal recovery", 0);
      end
    end

    rst_drv = 1'b1; tick(2); rst_drv = 1'b0; tick(4);
    div_on = 1'b1;
    for (int i = 0; i < DIV_N; i++) pulse();
    chk("R8 divide wrap", 0);
    for (int i = 0; i < 8; i++) pulse();
    chk("R8 divide modulo", 14 % DIV_N);
    div_on = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule